// File: doc/BRIEF.md
# Two-State Iterative Fibonacci Sequencer

The block returns the Fibonacci number F(n) for a small unsigned request n. A caller places n on the request input and pulses start while the block is idle. The block copies n into a down-counter, seeds a pair of registers with the values 1 and 0, and then advances the pair by one step per clock. When the counter reaches 1, the pair holds F(n), and the block flags completion.

Control uses only two states, idle and running. The completion flag is a combinational decode of the state and the counter. The result output is wired straight from the register that holds the newest term. Neither output has a flip-flop of its own. Sums wrap modulo 2^V_W. Requests from 1 to 2^N_W-1 are supported. A request of 0 is outside the supported range.

Top module: `fib_sequencer`

## Requirements
- R1: While rst is high at a rising clock edge, all state is cleared. Afterwards the block is idle, done is 0 and result is 0. A high rst in the middle of a run aborts the run in the same way.
- R2: While the block is idle and start is low, done stays 0 and the block stays idle.
- R3: When start is high at a rising edge while the block is idle, the block begins a run. In the cycle after that edge, result is 1. For n=1, done is already 1 in that cycle.
- R4: For a request n, done rises exactly n-1 cycles after the first running cycle. In that cycle result equals F(n), where F(0)=0, F(1)=1 and F(k)=F(k-1)+F(k-2).
- R5: done is high for exactly one cycle per run. After that cycle the block is idle again, and result keeps holding F(n).
- R6: Every addition wraps modulo 2^V_W. With the default widths, F(24)=46368 is the largest exact result, and for n≥25 the result is F(n) mod 65536.
- R7: start is ignored for the whole run, including the cycle in which done is high. It changes neither the timing of done nor the result.
- R8: After j steps of a run, with j below n-1, result shows F(j+1) and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when sampled high while idle |
| n_req | input | N_W | Index n of the requested term |
| result | output | V_W | Newest term of the register pair, combinational |
| done | output | 1 | One-cycle completion flag, combinational |

## Verification
The completion cycle and a new start request can fall in the same cycle. In that cycle the block is still running, so start must be ignored, and on the next edge the block must return to idle. The bench raises start on purpose in the cycle where done is high, and also holds start at random levels for the rest of the run. It then checks one cycle later that done is low and result still holds F(n), not the restart seed of 1. Random requests cover the whole range from 1 to 31, including the wrapping region, and every intermediate term is compared against a bench-side model.

// File: rtl/fib_pkg.sv
package fib_pkg;
    localparam int unsigned DEF_N_W = 5;
    localparam int unsigned DEF_V_W = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_cmd_t;
endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
    import fib_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     last,
    output logic     busy,
    output seq_cmd_t cmd
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        cmd.load = 1'b0;
        cmd.step = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd.load = 1'b1;
                    state_d  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (last) state_d = ST_IDLE;
                else      cmd.step = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/fib_counter.sv
module fib_counter #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] n_in,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= n_in;
        else if (step) cnt <= cnt - ONE;
    end

    assign last = (cnt <= ONE);
endmodule

// File: rtl/fib_pair.sv
module fib_pair #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] cur
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            prev <= '0;
        end else if (load) begin
            cur  <= W'(1);
            prev <= '0;
        end else if (step) begin
            cur  <= cur + prev;
            prev <= cur;
        end
    end
endmodule

// File: rtl/fib_sequencer.sv
module fib_sequencer
    import fib_pkg::*;
#(
    parameter int unsigned N_W = DEF_N_W,
    parameter int unsigned V_W = DEF_V_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] n_req,
    output logic [V_W-1:0] result,
    output logic           done
);
    seq_cmd_t       cmd;
    logic           busy;
    logic           last;
    logic [N_W-1:0] cnt_q;
    logic [V_W-1:0] cur_q;

    fib_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .busy  (busy),
        .cmd   (cmd)
    );

    fib_counter #(.CW(N_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (cmd.load),
        .step (cmd.step),
        .n_in (n_req),
        .cnt  (cnt_q),
        .last (last)
    );

    fib_pair #(.W(V_W)) u_pair (
        .clk  (clk),
        .rst  (rst),
        .load (cmd.load),
        .step (cmd.step),
        .cur  (cur_q)
    );

    assign done   = busy & last;
    assign result = cur_q;
endmodule

// File: rtl/fib_sequencer_chk.sv
module fib_sequencer_chk #(
    parameter int unsigned N_W = 5,
    parameter int unsigned V_W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N_W-1:0] n_req,
    input logic [V_W-1:0] result,
    input logic           done,
    input logic           busy,
    input logic [N_W-1:0] cnt
);
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !busy && result == '0));

    assert_idle_no_done_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !done);

    assert_start_loads_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && cnt == $past(n_req) && result == V_W'(1)));

    assert_step_counts_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && cnt == $past(cnt) - N_W'(1)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy && $stable(result)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);
endmodule

bind fib_sequencer fib_sequencer_chk #(.N_W(N_W), .V_W(V_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .n_req  (n_req),
    .result (result),
    .done   (done),
    .busy   (busy),
    .cnt    (cnt_q)
);

// File: tb/fib_sequencer_tb.sv
`timescale 1ns/1ps
module fib_sequencer_tb;
    localparam int N_W = 5;
    localparam int V_W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N_W-1:0] n_req = '0;
    logic [V_W-1:0] result;
    logic           done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    fib_sequencer #(.N_W(N_W), .V_W(V_W)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .n_req  (n_req),
        .result (result),
        .done   (done)
    );

    function automatic logic [V_W-1:0] fib_ref(input int k);
        logic [V_W-1:0] a, b, t;
        a = '0;
        b = V_W'(1);
        if (k == 0) return a;
        for (int i = 1; i < k; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return b;
    endfunction

    task automatic check(input string req, input logic [V_W-1:0] act,
                         input logic [V_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // One run; sampling and driving happen on falling edges.
    task automatic run(input int n, input bit noise);
        string rq;
        @(negedge clk);
        n_req = N_W'(n);
        start = 1'b1;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            n_req = N_W'($urandom_range(0, 31));
            start = noise ? 1'($urandom_range(0, 1)) : 1'b0;
            if (j == n - 1) begin
                if (noise) start = 1'b1;
                rq = (n >= 25) ? "R6" : "R4";
                check({rq, " done"}, V_W'(done), V_W'(1));
                check({rq, " result"}, result, fib_ref(n));
                if (n == 1) check("R3 n=1 result", result, V_W'(1));
            end else begin
                if (j == 0) check("R3 seed result", result, V_W'(1));
                check("R8 done low", V_W'(done), V_W'(0));
                check("R8 partial", result, fib_ref(j + 1));
            end
        end
        @(negedge clk);
        start = 1'b0;
        check("R5 done drops", V_W'(done), V_W'(0));
        check(noise ? "R7 result kept" : "R5 result kept", result, fib_ref(n));
        @(negedge clk);
        check("R2 idle done low", V_W'(done), V_W'(0));
        check(noise ? "R7 no restart" : "R2 idle result", result, fib_ref(n));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset done", V_W'(done), V_W'(0));
        check("R1 reset result", result, V_W'(0));
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 idle done", V_W'(done), V_W'(0));

        run(1, 0);
        run(2, 0);
        run(3, 1);
        run(24, 0);
        run(25, 1);
        run(31, 0);
        for (int n = 1; n <= 31; n++) run(n, n % 2);
        for (int r = 0; r < 20; r++) run($urandom_range(1, 31), 1);

        // R1: abort a run in flight
        @(negedge clk);
        n_req = 5'd20;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 abort done", V_W'(done), V_W'(0));
        check("R1 abort result", result, V_W'(0));
        repeat (25) @(negedge clk);
        check("R1 stays idle", V_W'(done), V_W'(0));
        run(7, 0);

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule